// File: doc/BRIEF.md
# CAN Frame Field Parser

The parser takes a stream of CAN bits from which stuff bits are already removed. Each bit comes with a one-cycle valid strobe. It supports both the 11-bit and the 29-bit identifier formats, and both data and remote frames. Every accepted bit gets an index, where index 0 is the start-of-frame bit. The parser uses the identifier-extension bit to choose which field map applies to the bits that follow. It computes the data length at run time from the length code. It then captures the identifiers, control bits, payload and CRC field.

Each bit of fixed form has its own error flag. The parser also drives a stuffing-enable output back to the destuffer. That output drops for the tail of the frame, which carries no stuff bits. When the last end-of-frame bit arrives, the parser pulses `frame_done` with every field and flag ready to read. It then treats the next valid bit as a new start of frame.

The parser does not compute the CRC, does not decode error or overload frames, and does not drive an acknowledge.

Top module: `can_field_parser`

## Requirements
- R1: The first valid bit after reset, or after a completed frame, is bit 0 (start of frame). When that bit is recessive (1), `err_sof` is set.
- R2: Bits 1..11 are shifted MSB first into `base_id`. When `base_id[10:4]` is all ones, `err_id` is set.
- R3: Bit 13 selects the format: 0 means base, 1 means extended (`ext_frame`). In a base frame, bit 12 is the remote flag and bit 14 is `rsv0`. Bits 15..18 are `dlc` and the payload starts at bit 19. `ext_id`, `srr` and `rsv1` read 0, and `full_id` equals `base_id` zero-extended.
- R4: In an extended frame, bit 12 is `srr` and bits 14..31 are `ext_id` (MSB first). Bit 32 is the remote flag, bit 33 is `rsv1` and bit 34 is `rsv0`. Bits 35..38 are `dlc`, the payload starts at bit 39, and `full_id = {base_id, ext_id}`.
- R5: The payload length in bytes equals `dlc`. It is 0 when the frame is remote or when `dlc > 8`, and `dlc > 8` also sets `err_dlc`. Payload bits are MSB first. Byte 0 lands in `data[63:56]`, byte 1 in `data[55:48]`, and so on. Bytes not received read 0.
- R6: The 15 bits right after the payload go MSB first into `crc`.
- R7: The bit after the CRC is the CRC delimiter; a dominant value there sets `err_crc_delim`. The next bit is the acknowledge slot, and `ack` = 1 when that slot is dominant. The bit after the slot is the acknowledge delimiter; a dominant value there sets `err_ack_delim`.
- R8: The seven bits after the acknowledge delimiter are end-of-frame bits. If any of them is dominant, `err_eof` is set.
- R9: `frame_done` is high for exactly one cycle, in the cycle after the strobe of the last end-of-frame bit. All fields and flags hold their values until the next start-of-frame bit clears them.
- R10: `stuff_en` is high out of reset and for every bit before the CRC delimiter. It is low while the next expected bit is at or after the CRC delimiter, and high again after the frame completes.
- R11: `bit_in` has no effect while `bit_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | Strobe: `bit_in` holds a destuffed bit |
| bit_in | input | 1 | Bit value, 1 = recessive |
| stuff_en | output | 1 | Destuffer enable |
| frame_done | output | 1 | One-cycle pulse: frame complete, fields valid |
| ext_frame | output | 1 | Extended format |
| remote | output | 1 | Remote frame |
| srr | output | 1 | Bit 12 of an extended frame |
| rsv0 | output | 1 | Reserved bit r0 |
| rsv1 | output | 1 | Reserved bit r1 (extended only) |
| base_id | output | 11 | Base identifier |
| ext_id | output | 18 | Identifier extension |
| full_id | output | 29 | Combined identifier |
| dlc | output | 4 | Length code as received |
| data | output | 64 | Payload, byte 0 in the top byte |
| crc | output | 15 | Received CRC field |
| ack | output | 1 | Acknowledge slot was dominant |
| err_sof | output | 1 | Start of frame recessive |
| err_id | output | 1 | Identifier bits 10..4 all recessive |
| err_dlc | output | 1 | Length code above 8 |
| err_crc_delim | output | 1 | CRC delimiter dominant |
| err_ack_delim | output | 1 | Acknowledge delimiter dominant |
| err_eof | output | 1 | Dominant bit in end of frame |

## Verification
The assertions check these properties on every cycle:
- `frame_done` is a single-cycle pulse that follows an accepted bit.
- Stuffing is enabled again when a frame completes.
- A remote frame has no payload.
- `err_dlc` agrees with the reported length code.
- A clean end-of-frame flag means the final bit was recessive.
- The bit index does not move without a strobe.

Only the bench scenarios can show whether each field lands at the right bit position for each format and length. The same holds for the payload and CRC boundaries moving with the length code, and for each fixed-form violation raising exactly its own flag. The bench also checks that the point where `stuff_en` drops follows the run-time length.

// File: rtl/can_field_parser.sv
module can_field_parser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_valid,
  input  logic        bit_in,
  output logic        stuff_en,
  output logic        frame_done,
  output logic        ext_frame,
  output logic        remote,
  output logic        srr,
  output logic        rsv0,
  output logic        rsv1,
  output logic [10:0] base_id,
  output logic [17:0] ext_id,
  output logic [28:0] full_id,
  output logic [3:0]  dlc,
  output logic [63:0] data,
  output logic [14:0] crc,
  output logic        ack,
  output logic        err_sof,
  output logic        err_id,
  output logic        err_dlc,
  output logic        err_crc_delim,
  output logic        err_ack_delim,
  output logic        err_eof
);
  localparam int IW = 7;
  localparam logic [IW-1:0] BASE_DSTART = IW'(19);
  localparam logic [IW-1:0] EXT_DSTART  = IW'(39);
  localparam logic [IW-1:0] CRC_LEN     = IW'(15);
  localparam logic [IW-1:0] TAIL_LAST   = IW'(24);

  logic [IW-1:0] idx;
  logic          b12, rtr_x, r1_q;
  logic [3:0]    len;
  logic [IW-1:0] dstart, crc_start, doff, dlc_last;

  assign remote    = ext_frame ? rtr_x : b12;
  assign srr       = ext_frame & b12;
  assign rsv1      = ext_frame & r1_q;
  assign full_id   = ext_frame ? {base_id, ext_id} : {18'd0, base_id};
  assign len       = (remote || dlc > 4'd8) ? 4'd0 : dlc;
  assign dstart    = ext_frame ? EXT_DSTART : BASE_DSTART;
  assign dlc_last  = dstart - IW'(1);
  assign crc_start = dstart + {len, 3'b000};
  assign doff      = idx - dstart;
  assign stuff_en  = idx < crc_start + CRC_LEN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0; frame_done <= 1'b0;
      ext_frame <= 1'b0; b12 <= 1'b0; rtr_x <= 1'b0; r1_q <= 1'b0; rsv0 <= 1'b0;
      base_id <= '0; ext_id <= '0; dlc <= '0; data <= '0; crc <= '0; ack <= 1'b0;
      err_sof <= 1'b0; err_id <= 1'b0; err_dlc <= 1'b0;
      err_crc_delim <= 1'b0; err_ack_delim <= 1'b0; err_eof <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (bit_valid) begin
        idx <= idx + IW'(1);
        if (idx == '0) begin
          ext_frame <= 1'b0; b12 <= 1'b0; rtr_x <= 1'b0; r1_q <= 1'b0; rsv0 <= 1'b0;
          base_id <= '0; ext_id <= '0; dlc <= '0; data <= '0; crc <= '0; ack <= 1'b0;
          err_sof <= bit_in; err_id <= 1'b0; err_dlc <= 1'b0;
          err_crc_delim <= 1'b0; err_ack_delim <= 1'b0; err_eof <= 1'b0;
        end
        if (idx >= IW'(1) && idx <= IW'(11)) base_id <= {base_id[9:0], bit_in};
        if (idx == IW'(11) && &base_id[9:3]) err_id <= 1'b1;
        if (idx == IW'(12)) b12 <= bit_in;
        if (idx == IW'(13)) ext_frame <= bit_in;
        if (!ext_frame) begin
          if (idx == IW'(14)) rsv0 <= bit_in;
          if (idx >= IW'(15) && idx <= IW'(18)) dlc <= {dlc[2:0], bit_in};
        end else begin
          if (idx >= IW'(14) && idx <= IW'(31)) ext_id <= {ext_id[16:0], bit_in};
          if (idx == IW'(32)) rtr_x <= bit_in;
          if (idx == IW'(33)) r1_q <= bit_in;
          if (idx == IW'(34)) rsv0 <= bit_in;
          if (idx >= IW'(35) && idx <= IW'(38)) dlc <= {dlc[2:0], bit_in};
        end
        if (idx >= IW'(14) && idx == dlc_last && {dlc[2:0], bit_in} > 4'd8) err_dlc <= 1'b1;
        if (idx >= dstart && idx < crc_start) data[~doff[5:0]] <= bit_in;
        if (idx >= crc_start && idx < crc_start + CRC_LEN) crc <= {crc[13:0], bit_in};
        if (idx == crc_start + CRC_LEN && !bit_in) err_crc_delim <= 1'b1;
        if (idx == crc_start + IW'(16)) ack <= !bit_in;
        if (idx == crc_start + IW'(17) && !bit_in) err_ack_delim <= 1'b1;
        if (idx >= crc_start + IW'(18) && !bit_in) err_eof <= 1'b1;
        if (idx == crc_start + TAIL_LAST) begin
          idx <= '0;
          frame_done <= 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  assert_done_after_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(bit_valid));
  assert_stuff_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> stuff_en);
  assert_remote_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && remote) |-> data == '0);
  assert_dlc_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (err_dlc == (dlc > 4'd8)));
  assert_eof_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !err_eof) |-> $past(bit_in));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> ($stable(idx) && $stable(data) && $stable(crc)));
endmodule

// File: tb/sim_can_field_parser.sv
module sim_can_field_parser;
  logic clk = 1'b0, rst_n = 1'b0, bit_valid = 1'b0, bit_in = 1'b1;
  logic stuff_en, frame_done, ext_frame, remote, srr, rsv0, rsv1, ack;
  logic [10:0] base_id; logic [17:0] ext_id; logic [28:0] full_id;
  logic [3:0] dlc; logic [63:0] data; logic [14:0] crc;
  logic err_sof, err_id, err_dlc, err_crc_delim, err_ack_delim, err_eof;

  int checks = 0, errors = 0, frames_seen = 0;

  typedef struct packed {
    logic ext, rtr, srr, r0, r1;
    logic [10:0] id; logic [17:0] eid; logic [3:0] dlc;
    logic [63:0] data; logic [14:0] crc; logic ack;
    logic [5:0] err;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  can_field_parser u0 (.*);

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic ext, input logic [10:0] id, input logic [17:0] eid,
                      input logic rtr, input logic s, input logic r0, input logic r1,
                      input logic [3:0] dl, input logic [63:0] d, input logic [14:0] c,
                      input logic a, input logic [3:0] bad);
    logic b[128];
    int n = 0, len, crcs;
    exp_t e;
    b[n] = bad[3]; n++;
    for (int i = 10; i >= 0; i--) begin b[n] = id[i]; n++; end
    if (!ext) begin
      b[n] = rtr; n++; b[n] = 1'b0; n++; b[n] = r0; n++;
    end else begin
      b[n] = s; n++; b[n] = 1'b1; n++;
      for (int i = 17; i >= 0; i--) begin b[n] = eid[i]; n++; end
      b[n] = rtr; n++; b[n] = r1; n++; b[n] = r0; n++;
    end
    for (int i = 3; i >= 0; i--) begin b[n] = dl[i]; n++; end
    len = (rtr || dl > 4'd8) ? 0 : int'(dl);
    e = '0;
    for (int i = 0; i < 8 * len; i++) begin b[n] = d[63 - i]; e.data[63 - i] = d[63 - i]; n++; end
    crcs = n;
    for (int i = 14; i >= 0; i--) begin b[n] = c[i]; n++; end
    b[n] = !bad[2]; n++; b[n] = !a; n++; b[n] = !bad[1]; n++;
    for (int i = 0; i < 7; i++) begin b[n] = 1'b1; n++; end
    if (bad[0]) b[n - 3] = 1'b0;
    e.ext = ext; e.rtr = rtr; e.srr = ext & s; e.r0 = r0; e.r1 = ext & r1;
    e.id = id; e.eid = ext ? eid : 18'd0; e.dlc = dl; e.crc = c; e.ack = a;
    e.err = {bad[3], &id[10:4], dl > 4'd8, bad[2], bad[1], bad[0]};
    q.push_back(e);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(stuff_en == (k < crcs + 15), "R10 stuff_en", 64'(stuff_en), 64'(k < crcs + 15));
      bit_valid = 1'b1; bit_in = b[k];
      @(negedge clk);
      bit_valid = 1'b0; bit_in = 1'($urandom);
      if (k % 3 == 0) begin @(negedge clk); bit_in = 1'($urandom); end
    end
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && frame_done) begin
      exp_t e;
      frames_seen++;
      if (q.size() == 0) chk(1'b0, "R9 unexpected frame_done", 1, 0);
      else begin
        e = q.pop_front();
        chk(ext_frame == e.ext, "R3 ext_frame", 64'(ext_frame), 64'(e.ext));
        chk(remote == e.rtr, "R3/R4 remote", 64'(remote), 64'(e.rtr));
        chk(srr == e.srr, "R4 srr", 64'(srr), 64'(e.srr));
        chk(rsv0 == e.r0 && rsv1 == e.r1, "R4 reserved", 64'({rsv1, rsv0}), 64'({e.r1, e.r0}));
        chk(base_id == e.id, "R2 base_id", 64'(base_id), 64'(e.id));
        chk(ext_id == e.eid, "R4 ext_id", 64'(ext_id), 64'(e.eid));
        chk(full_id == (e.ext ? {e.id, e.eid} : {18'd0, e.id}), "R4 full_id", 64'(full_id),
            64'(e.ext ? {e.id, e.eid} : {18'd0, e.id}));
        chk(dlc == e.dlc, "R3 dlc", 64'(dlc), 64'(e.dlc));
        chk(data == e.data, "R5 data", data, e.data);
        chk(crc == e.crc, "R6 crc", 64'(crc), 64'(e.crc));
        chk(ack == e.ack, "R7 ack", 64'(ack), 64'(e.ack));
        chk({err_sof, err_id, err_dlc, err_crc_delim, err_ack_delim, err_eof} == e.err,
            "R1/R2/R5/R7/R8 flags",
            64'({err_sof, err_id, err_dlc, err_crc_delim, err_ack_delim, err_eof}), 64'(e.err));
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [10:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stuff_en && !frame_done, "R10 reset state", 64'({stuff_en, frame_done}), 64'b10);
    chk({err_sof, err_id, err_dlc, err_crc_delim, err_ack_delim, err_eof} == 6'b0,
        "R1 reset flags", 64'({err_sof, err_id, err_dlc, err_crc_delim, err_ack_delim, err_eof}), 0);
    // base data frame, two bytes (R3, R5, R6)
    send(1'b0, 11'h123, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 64'hABCD_1122_3344_5566, 15'h1A2B, 1'b1, 4'b0000);
    // extended data frame, eight bytes (R4)
    send(1'b1, 11'h0A5, 18'h2BEEF, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8, 64'h0102_0304_A5B6_C7D8, 15'h7FFF, 1'b1, 4'b0000);
    // base remote frame: length 0 (R5)
    send(1'b0, 11'h456, 18'h0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4, 64'hFFFF_FFFF_FFFF_FFFF, 15'h0001, 1'b1, 4'b0000);
    // length code above 8 (R5)
    send(1'b0, 11'h010, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9, 64'hDEAD_BEEF_0000_0000, 15'h4321, 1'b0, 4'b0000);
    // every fixed-form violation, recessive id[10:4], NACK (R1, R2, R7, R8)
    send(1'b0, 11'h7F5, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 64'h5A00_0000_0000_0000, 15'h2AAA, 1'b0, 4'b1111);
    // extended remote frame, reserved bits recessive (R4)
    send(1'b1, 11'h3C3, 18'h00001, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 64'h0, 15'h5555, 1'b1, 4'b0000);
    // R11: junk on bit_in without strobe
    held = base_id;
    for (int i = 0; i < 20; i++) begin @(negedge clk); bit_in = 1'($urandom); end
    chk(base_id == held && stuff_en && !frame_done, "R11 ignored input", 64'(base_id), 64'(held));
    // back-to-back frame after the idle gap: starts at bit 0 again (R9)
    send(1'b0, 11'h001, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 64'h8000_0000_0000_0000, 15'h0F0F, 1'b1, 4'b0000);
    repeat (4) @(negedge clk);
    chk(frames_seen == 7 && q.size() == 0, "R9 frame count", 64'(frames_seen), 7);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule